// File: doc/BRIEF.md
# Auxiliary-Channel Request Engine

This block is a small byte-wide register file through which a host processor builds and launches a single display auxiliary-channel transaction. The host loads a 20-bit target address, a 4-bit request code and a coded payload length. For write requests it also loads the payload into a write FIFO. It then sets a start bit. The engine presents the request on a simple request/response port to a link-layer responder. Bytes move across that port one per cycle, and the responder ends the transaction with a reply code. The engine then publishes a result class and a byte count in a status register. Any read data waits in a read FIFO for the host.

A programmable cycle limit bounds the wait for a reply. A clear command written to a configuration register brings the channel back to an empty state before the next transaction is set up. Host pushes into a full write FIFO and host pops from an empty read FIFO are dropped. Each leaves a sticky flag.

Top module: `aux_req_engine`

## Requirements
- R1: Register offsets are 0 address bits 7:0, 1 address bits 15:8, 2 address bits 19:16 in bits 3:0 with the request code in bits 7:4, 3 length, 4 write data, 5 read data, 6 control, 7 status, 8 channel clear, 9 error flags, 10 reply timeout. Registers 0 to 3 and 10 read back what was written. One cycle after a host write of 1 to control bit 0 that starts a valid request, `lk_req` is high for exactly one cycle, and `lk_addr` and `lk_cmd` carry the captured address and code.
- R2: The length register holds byte count minus one in bits 3:0, and bit 7 marks a transaction with no payload. `lk_len` equals 0 when bit 7 is set and bits 3:0 plus one otherwise.
- R3: Only codes 0x8 (native write), 0x9 (native read), 0x0 (I2C write) and 0x1 (I2C read) are valid. Starting with any other code raises no `lk_req`, keeps control bit 0 at 0, and sets status to 0x80.
- R4: Each host write to offset 4 appends a byte to the write FIFO. On a write request, `lk_wdata` shows the oldest byte, and each cycle with `lk_wtake` high consumes it.
- R5: Control bit 0 reads 1 while a transaction is in flight and returns to 0 by itself on completion. A start written while busy is ignored.
- R6: Status bits 7:5 give the result class. Reply code 0 gives class 3 (ACK). Reply code 2 gives class 2 for native requests and class 6 for I2C requests. Reply codes 1 and 3 give class 1 for native requests and class 5 for I2C requests. Starting a transaction sets status to 0.
- R7: Status bits 4:0 count the bytes actually moved, including any beat in the reply cycle. Beats beyond the programmed length are not counted and are not stored. A read beat is stored only while the read FIFO is not full.
- R8: If no reply arrives within the first N busy cycles, where N is the value at offset 10 (default 64), the transaction ends with status 0xE0. A reply in the N-th cycle still wins. A reply arriving later is ignored.
- R9: Each host read of offset 5 pops the oldest read-FIFO byte. Read data of any register is valid on `reg_rdata` one cycle after `reg_re`.
- R10: Writing 0xFF to offset 8 empties both FIFOs, zeroes status and the error flags, and ends any transaction in flight.
- R11: A push into a full write FIFO is dropped and sets error bit 0. A pop from an empty read FIFO is dropped, returns 0 and sets error bit 1. Both bits stay set until cleared by R10.
- R12: After reset, status, control and error flags read 0 and the timeout register reads 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | RA_W | Host register offset |
| reg_we | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write data |
| reg_re | input | 1 | Host read strobe |
| reg_rdata | output | 8 | Host read data, one cycle after `reg_re` |
| lk_req | output | 1 | One-cycle request launch pulse |
| lk_cmd | output | 4 | Captured request code |
| lk_addr | output | 20 | Captured target address |
| lk_len | output | 5 | Payload bytes requested (0 to 16) |
| lk_wdata | output | 8 | Oldest write-FIFO byte |
| lk_wtake | input | 1 | Responder consumes one write byte |
| lk_rdata | input | 8 | Read byte from responder |
| lk_rvalid | input | 1 | Read byte valid |
| lk_rsp_valid | input | 1 | Reply present, ends the transaction |
| lk_rsp_code | input | 2 | Reply code: 0 ACK, 1 NACK, 2 DEFER, 3 treated as NACK |

## Verification
The reply from the responder and the expiry of the reply timer can land in the same cycle. The engine must then report the reply and not a timeout. The bench sets the limit to 8 and delivers an ACK exactly in the eighth busy cycle, which must give status 0x60. It then repeats the case with the ACK one cycle later, which must give 0xE0 and leave the late reply without effect. A second coincidence, a host read-FIFO pop in the same cycle as a responder push, is covered by the per-cycle model. That model evaluates the pop against the FIFO contents before the push.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;

  localparam int unsigned CNT_W  = 5;   // byte count field, 0..16
  localparam int unsigned ADDR_W = 20;

  typedef enum logic [2:0] {
    CLS_NONE      = 3'd0,
    CLS_NACK      = 3'd1,
    CLS_DEFER     = 3'd2,
    CLS_ACK       = 3'd3,
    CLS_INVALID   = 3'd4,
    CLS_I2C_NACK  = 3'd5,
    CLS_I2C_DEFER = 3'd6,
    CLS_TIMEOUT   = 3'd7
  } cls_e;

  localparam logic [3:0] CMD_I2C_WR = 4'h0;
  localparam logic [3:0] CMD_I2C_RD = 4'h1;
  localparam logic [3:0] CMD_NAT_WR = 4'h8;
  localparam logic [3:0] CMD_NAT_RD = 4'h9;

  function automatic logic cmd_ok(input logic [3:0] c);
    return (c == CMD_I2C_WR) || (c == CMD_I2C_RD) ||
           (c == CMD_NAT_WR) || (c == CMD_NAT_RD);
  endfunction

  function automatic logic cmd_native(input logic [3:0] c);
    return c[3];
  endfunction

  function automatic logic cmd_read(input logic [3:0] c);
    return c[0];
  endfunction

  // coded length register -> bytes requested
  function automatic logic [CNT_W-1:0] want_bytes(input logic nopay, input logic [3:0] lc);
    return nopay ? '0 : (CNT_W'(lc) + CNT_W'(1));
  endfunction

  function automatic cls_e reply_class(input logic [1:0] code, input logic native);
    case (code)
      2'd0:    return CLS_ACK;
      2'd2:    return native ? CLS_DEFER : CLS_I2C_DEFER;
      default: return native ? CLS_NACK  : CLS_I2C_NACK;
    endcase
  endfunction

endpackage

// File: rtl/aux_byte_fifo.sv
module aux_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign head    = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= bump(wp_q);
      if (do_pop)  rp_q <= bump(rp_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

endmodule

// File: rtl/aux_xact_ctrl.sv
module aux_xact_ctrl import aux_req_pkg::*; #(
  parameter int TO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              nopay,
  input  logic [3:0]        lcode,
  input  logic [TO_W-1:0]   to_lim,
  input  logic              lk_wtake,
  input  logic              wf_empty,
  input  logic              lk_rvalid,
  input  logic              rf_full,
  input  logic              lk_rsp_valid,
  input  logic [1:0]        lk_rsp_code,
  output logic              busy,
  output logic              done,
  output logic [7:0]        status,
  output logic              lk_req,
  output logic [3:0]        lk_cmd,
  output logic [ADDR_W-1:0] lk_addr,
  output logic [CNT_W-1:0]  lk_len,
  output logic              wf_pop,
  output logic              rf_push
);
  logic              run_q, req_q;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  need_q, moved_q, moved_nx;
  logic [TO_W-1:0]   tcnt_q;
  logic [7:0]        status_q;
  logic              is_rd, beat, expire, fin_rsp, good_start, bad_start;

  assign is_rd      = cmd_read(cmd_q);
  assign fin_rsp    = run_q && lk_rsp_valid;
  assign expire     = run_q && !lk_rsp_valid &&
                      (({1'b0, tcnt_q} + (TO_W+1)'(1)) >= {1'b0, to_lim});
  assign beat       = run_q && !expire && (moved_q < need_q) &&
                      (is_rd ? (lk_rvalid && !rf_full) : (lk_wtake && !wf_empty));
  assign wf_pop     = beat && !is_rd;
  assign rf_push    = beat && is_rd;
  assign moved_nx   = moved_q + CNT_W'(beat);
  assign good_start = start && !run_q && cmd_ok(cmd);
  assign bad_start  = start && !run_q && !cmd_ok(cmd);
  assign done       = fin_rsp || expire || bad_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      req_q    <= 1'b0;
      cmd_q    <= '0;
      addr_q   <= '0;
      need_q   <= '0;
      moved_q  <= '0;
      tcnt_q   <= '0;
      status_q <= '0;
    end else if (clr) begin
      run_q    <= 1'b0;
      req_q    <= 1'b0;
      status_q <= '0;
    end else begin
      req_q <= good_start;
      if (good_start) begin
        run_q    <= 1'b1;
        cmd_q    <= cmd;
        addr_q   <= addr;
        need_q   <= want_bytes(nopay, lcode);
        moved_q  <= '0;
        tcnt_q   <= '0;
        status_q <= '0;
      end else if (bad_start) begin
        status_q <= {CLS_INVALID, {CNT_W{1'b0}}};
      end else if (run_q) begin
        moved_q <= moved_nx;
        tcnt_q  <= tcnt_q + TO_W'(1);
        if (fin_rsp) begin
          run_q    <= 1'b0;
          status_q <= {reply_class(lk_rsp_code, cmd_native(cmd_q)), moved_nx};
        end else if (expire) begin
          run_q    <= 1'b0;
          status_q <= {CLS_TIMEOUT, {CNT_W{1'b0}}};
        end
      end
    end
  end

  assign busy    = run_q;
  assign status  = status_q;
  assign lk_req  = req_q;
  assign lk_cmd  = cmd_q;
  assign lk_addr = addr_q;
  assign lk_len  = need_q;

endmodule

// File: rtl/aux_req_engine.sv
module aux_req_engine import aux_req_pkg::*; #(
  parameter int          RA_W       = 4,
  parameter int          FIFO_DEPTH = 16,
  parameter int          TO_W       = 8,
  parameter int unsigned TO_RESET   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  input  logic              reg_re,
  output logic [7:0]        reg_rdata,
  output logic              lk_req,
  output logic [3:0]        lk_cmd,
  output logic [ADDR_W-1:0] lk_addr,
  output logic [CNT_W-1:0]  lk_len,
  output logic [7:0]        lk_wdata,
  input  logic              lk_wtake,
  input  logic [7:0]        lk_rdata,
  input  logic              lk_rvalid,
  input  logic              lk_rsp_valid,
  input  logic [1:0]        lk_rsp_code
);
  localparam logic [RA_W-1:0] R_ADR0  = RA_W'(0);
  localparam logic [RA_W-1:0] R_ADR1  = RA_W'(1);
  localparam logic [RA_W-1:0] R_ADR2  = RA_W'(2);
  localparam logic [RA_W-1:0] R_LEN   = RA_W'(3);
  localparam logic [RA_W-1:0] R_WDAT  = RA_W'(4);
  localparam logic [RA_W-1:0] R_RDAT  = RA_W'(5);
  localparam logic [RA_W-1:0] R_CTRL  = RA_W'(6);
  localparam logic [RA_W-1:0] R_STAT  = RA_W'(7);
  localparam logic [RA_W-1:0] R_CHCFG = RA_W'(8);
  localparam logic [RA_W-1:0] R_ERR   = RA_W'(9);
  localparam logic [RA_W-1:0] R_TMO   = RA_W'(10);
  localparam logic [7:0]      CLR_KEY = 8'hFF;

  logic [7:0]      adr0_q, adr1_q, adr2_q, len_q;
  logic [TO_W-1:0] tmo_q;
  logic [1:0]      err_q;
  logic [7:0]      rd_mux, rdata_q, stat_byte;
  logic            chcfg_clr, start_req, push_req, pop_req;
  logic            ovf_ev, udf_ev;
  logic            wf_full, wf_empty, wf_pop, rf_full, rf_empty, rf_push;
  logic [7:0]      rf_head;
  logic            busy, xact_done;

  // decoded host events
  assign chcfg_clr = reg_we && (reg_addr == R_CHCFG) && (reg_wdata == CLR_KEY);
  assign start_req = reg_we && (reg_addr == R_CTRL) && reg_wdata[0];
  assign push_req  = reg_we && (reg_addr == R_WDAT);
  assign pop_req   = reg_re && (reg_addr == R_RDAT);
  assign ovf_ev    = push_req && wf_full;
  assign udf_ev    = pop_req && rf_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr0_q <= '0;
      adr1_q <= '0;
      adr2_q <= '0;
      len_q  <= '0;
      tmo_q  <= TO_W'(TO_RESET);
      err_q  <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          R_ADR0:  adr0_q <= reg_wdata;
          R_ADR1:  adr1_q <= reg_wdata;
          R_ADR2:  adr2_q <= reg_wdata;
          R_LEN:   len_q  <= reg_wdata;
          R_TMO:   tmo_q  <= TO_W'(reg_wdata);
          default: ;
        endcase
      end
      if (chcfg_clr) begin
        err_q <= '0;
      end else begin
        if (ovf_ev) err_q[0] <= 1'b1;
        if (udf_ev) err_q[1] <= 1'b1;
      end
    end
  end

  aux_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_wfifo (
    .clk(clk), .rst_n(rst_n), .clr(chcfg_clr),
    .push(push_req), .din(reg_wdata), .pop(wf_pop),
    .head(lk_wdata), .full(wf_full), .empty(wf_empty)
  );

  aux_byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rfifo (
    .clk(clk), .rst_n(rst_n), .clr(chcfg_clr),
    .push(rf_push), .din(lk_rdata), .pop(pop_req),
    .head(rf_head), .full(rf_full), .empty(rf_empty)
  );

  aux_xact_ctrl #(.TO_W(TO_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(chcfg_clr), .start(start_req),
    .cmd(adr2_q[7:4]), .addr({adr2_q[3:0], adr1_q, adr0_q}),
    .nopay(len_q[7]), .lcode(len_q[3:0]), .to_lim(tmo_q),
    .lk_wtake(lk_wtake), .wf_empty(wf_empty),
    .lk_rvalid(lk_rvalid), .rf_full(rf_full),
    .lk_rsp_valid(lk_rsp_valid), .lk_rsp_code(lk_rsp_code),
    .busy(busy), .done(xact_done), .status(stat_byte),
    .lk_req(lk_req), .lk_cmd(lk_cmd), .lk_addr(lk_addr), .lk_len(lk_len),
    .wf_pop(wf_pop), .rf_push(rf_push)
  );

  always_comb begin
    case (reg_addr)
      R_ADR0:  rd_mux = adr0_q;
      R_ADR1:  rd_mux = adr1_q;
      R_ADR2:  rd_mux = adr2_q;
      R_LEN:   rd_mux = len_q;
      R_RDAT:  rd_mux = rf_empty ? 8'h00 : rf_head;
      R_CTRL:  rd_mux = {7'b0, busy};
      R_STAT:  rd_mux = stat_byte;
      R_ERR:   rd_mux = {6'b0, err_q};
      R_TMO:   rd_mux = 8'(tmo_q);
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_re) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/aux_req_checker.sv
module aux_req_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       clr,
  input logic       busy,
  input logic       done,
  input logic [7:0] status,
  input logic       lk_req,
  input logic [4:0] lk_len,
  input logic       lk_rsp_valid,
  input logic [1:0] err,
  input logic       wf_empty,
  input logic       rf_empty
);
  // R1: launch is a single-cycle pulse issued while in flight
  a_r1_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> !lk_req);
  a_r1_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> busy);
  // R5: a reply ends the transaction
  a_r5_reply_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lk_rsp_valid) |=> !busy);
  // R7: reported count never exceeds the requested length
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done && !clr) |=> (status[4:0] <= $past(lk_len)));
  // R8: timeout always reports zero bytes
  a_r8_timeout_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:5] == 3'd7) |-> (status[4:0] == 5'd0));
  // R3: invalid class always reports zero bytes
  a_r3_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:5] == 3'd4) |-> (status[4:0] == 5'd0));
  // R10: channel clear empties everything
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (status == 8'h00 && !busy && wf_empty && rf_empty && err == 2'b00));
  // R11: error flags are sticky
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err[0] && !clr) |=> err[0]);
  a_r11_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err[1] && !clr) |=> err[1]);
endmodule

bind aux_req_engine aux_req_checker u_chk (
  .clk(clk), .rst_n(rst_n), .clr(chcfg_clr), .busy(busy), .done(xact_done),
  .status(stat_byte), .lk_req(lk_req), .lk_len(lk_len),
  .lk_rsp_valid(lk_rsp_valid), .err(err_q),
  .wf_empty(wf_empty), .rf_empty(rf_empty)
);

// File: tb/aux_req_engine_tb.sv
module aux_req_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        lk_req;
  logic [3:0]  lk_cmd;
  logic [19:0] lk_addr;
  logic [4:0]  lk_len;
  logic [7:0]  lk_wdata;
  logic        lk_wtake = 1'b0;
  logic [7:0]  lk_rdata = '0;
  logic        lk_rvalid = 1'b0, lk_rsp_valid = 1'b0;
  logic [1:0]  lk_rsp_code = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  aux_req_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .lk_req(lk_req), .lk_cmd(lk_cmd), .lk_addr(lk_addr), .lk_len(lk_len),
    .lk_wdata(lk_wdata), .lk_wtake(lk_wtake), .lk_rdata(lk_rdata),
    .lk_rvalid(lk_rvalid), .lk_rsp_valid(lk_rsp_valid), .lk_rsp_code(lk_rsp_code)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  byte unsigned wq[$], rq[$];
  bit          m_busy = 0, m_req = 0, m_rd = 0, m_nat = 0, rd_chk = 0;
  int          m_tcnt = 0, m_moved = 0, m_need = 0;
  logic [3:0]  m_cmd = '0, rd_a = '0;
  logic [19:0] m_addr = '0;
  logic [7:0]  m_a0 = 0, m_a1 = 0, m_a2 = 0, m_len = 0, m_stat = 0, m_lim = 64, m_rexp = 0;
  logic [1:0]  m_err = 0;

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd5: return "R9";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd9: return "R11";
      4'd10: return "R8";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    bit clr, b0, fin, expd, beat, wfull, rfull, valid;
    logic [3:0] c;
    m_req = 0;
    rd_chk = 0;
    if (!rst_n) begin
      wq.delete(); rq.delete();
      m_busy = 0; m_stat = 0; m_err = 0; m_lim = 64;
      m_a0 = 0; m_a1 = 0; m_a2 = 0; m_len = 0;
    end else begin
      b0 = m_busy;
      clr = reg_we && reg_addr == 4'd8 && reg_wdata == 8'hFF;
      if (reg_re) begin
        rd_chk = 1; rd_a = reg_addr;
        case (reg_addr)
          4'd0: m_rexp = m_a0;
          4'd1: m_rexp = m_a1;
          4'd2: m_rexp = m_a2;
          4'd3: m_rexp = m_len;
          4'd5: m_rexp = (rq.size() > 0) ? rq[0] : 8'h00;
          4'd6: m_rexp = {7'b0, m_busy};
          4'd7: m_rexp = m_stat;
          4'd9: m_rexp = {6'b0, m_err};
          4'd10: m_rexp = m_lim;
          default: m_rexp = 8'h00;
        endcase
      end
      if (clr) begin
        wq.delete(); rq.delete();
        m_stat = 0; m_err = 0; m_busy = 0;
      end else begin
        wfull = wq.size() >= 16;
        rfull = rq.size() >= 16;
        fin = 0; expd = 0; beat = 0;
        if (b0) begin
          fin  = lk_rsp_valid;
          expd = !fin && (m_tcnt + 1 >= int'(m_lim));
          beat = !expd && (m_moved < m_need) &&
                 (m_rd ? (lk_rvalid && !rfull) : (lk_wtake && wq.size() > 0));
        end
        if (reg_re && reg_addr == 4'd5) begin
          if (rq.size() > 0) void'(rq.pop_front());
          else m_err[1] = 1;
        end
        if (beat) begin
          if (m_rd) rq.push_back(lk_rdata);
          else void'(wq.pop_front());
          m_moved++;
        end
        if (reg_we && reg_addr == 4'd4) begin
          if (wfull) m_err[0] = 1;
          else wq.push_back(reg_wdata);
        end
        if (b0) begin
          if (fin) begin
            m_busy = 0;
            case (lk_rsp_code)
              2'd0: m_stat[7:5] = 3'd3;
              2'd2: m_stat[7:5] = m_nat ? 3'd2 : 3'd6;
              default: m_stat[7:5] = m_nat ? 3'd1 : 3'd5;
            endcase
            m_stat[4:0] = 5'(m_moved);
          end else if (expd) begin
            m_busy = 0; m_stat = 8'hE0;
          end else m_tcnt++;
        end
        if (reg_we && reg_addr == 4'd6 && reg_wdata[0] && !b0) begin
          c = m_a2[7:4];
          valid = (c == 4'h0) || (c == 4'h1) || (c == 4'h8) || (c == 4'h9);
          if (valid) begin
            m_req = 1; m_busy = 1; m_cmd = c; m_rd = c[0]; m_nat = c[3];
            m_addr = {m_a2[3:0], m_a1, m_a0};
            m_need = m_len[7] ? 0 : int'(m_len[3:0]) + 1;
            m_stat = 0; m_tcnt = 0; m_moved = 0;
          end else m_stat = 8'h80;
        end
        if (reg_we) begin
          case (reg_addr)
            4'd0: m_a0 = reg_wdata;
            4'd1: m_a1 = reg_wdata;
            4'd2: m_a2 = reg_wdata;
            4'd3: m_len = reg_wdata;
            4'd10: m_lim = reg_wdata;
            default: ;
          endcase
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1", lk_req, m_req);
      if (m_req) begin
        chk("R1", lk_addr, m_addr);
        chk("R1", lk_cmd, m_cmd);
        chk("R2", lk_len, m_need);
      end
      if (m_busy && !m_rd && wq.size() > 0) chk("R4", lk_wdata, wq[0]);
      if (rd_chk) chk(tag_of(rd_a), reg_rdata, m_rexp);
    end
  end

  // ---------------- stimulus helpers (called at a negedge) ----------------
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; reg_re = 1;
    @(negedge clk);
    reg_re = 0;
    d = reg_rdata;
  endtask

  task automatic start_tx(input logic [19:0] adr, input logic [3:0] cmd, input logic [7:0] len);
    wr(4'd0, adr[7:0]);
    wr(4'd1, adr[15:8]);
    wr(4'd2, {cmd, adr[19:16]});
    wr(4'd3, len);
    wr(4'd6, 8'h01);
  endtask

  task automatic rsp_after(input int d, input logic [1:0] code);
    repeat (d) @(negedge clk);
    lk_rsp_valid = 1; lk_rsp_code = code;
    @(negedge clk);
    lk_rsp_valid = 0;
  endtask

  task automatic rbeats(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      lk_rvalid = 1; lk_rdata = base + 8'(i);
      @(negedge clk);
    end
    lk_rvalid = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(4'd6, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_sim();
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12: reset state
    rd(4'd7, v);  chk("R12", v, 8'h00);
    rd(4'd6, v);  chk("R12", v, 8'h00);
    rd(4'd9, v);  chk("R12", v, 8'h00);
    rd(4'd10, v); chk("R12", v, 8'd64);
    wr(4'd10, 8'd8);

    // R4/R6/R7: native write of three bytes, ACK
    wr(4'd4, 8'hAA); wr(4'd4, 8'hBB); wr(4'd4, 8'hCC);
    start_tx(20'h12345, 4'h8, 8'h02);
    chk("R1", lk_req, 1'b1);
    chk("R1", lk_addr, 20'h12345);
    chk("R2", lk_len, 5'd3);
    for (int i = 0; i < 3; i++) begin
      lk_wtake = 1;
      chk("R4", lk_wdata, 8'hAA + 8'(i * 17));
      @(negedge clk);
    end
    lk_wtake = 0;
    rsp_after(0, 2'd0);
    wait_idle();
    rd(4'd7, v); chk("R6", v, 8'h63);

    // R7/R9/R11: I2C read, DEFER after two bytes, then underflow
    start_tx(20'h00050, 4'h1, 8'h03);
    rbeats(2, 8'h11);
    rsp_after(0, 2'd2);
    wait_idle();
    rd(4'd7, v); chk("R6", v, 8'hC2);
    rd(4'd5, v); chk("R9", v, 8'h11);
    rd(4'd5, v); chk("R9", v, 8'h12);
    rd(4'd5, v); chk("R11", v, 8'h00);
    rd(4'd9, v); chk("R11", v, 8'h02);
    rd(4'd9, v); chk("R11", v, 8'h02);
    wr(4'd8, 8'hFF);
    rd(4'd9, v); chk("R10", v, 8'h00);
    rd(4'd7, v); chk("R10", v, 8'h00);

    // R7: native read of two bytes, responder offers three
    start_tx(20'hFFFFF, 4'h9, 8'h01);
    rbeats(3, 8'h5A);
    rsp_after(0, 2'd0);
    wait_idle();
    rd(4'd7, v); chk("R7", v, 8'h62);
    rd(4'd5, v); chk("R7", v, 8'h5A);
    rd(4'd5, v); chk("R7", v, 8'h5B);

    // R3: invalid request code
    start_tx(20'h00001, 4'h3, 8'h00);
    chk("R3", lk_req, 1'b0);
    rd(4'd7, v); chk("R3", v, 8'h80);
    rd(4'd6, v); chk("R3", v, 8'h00);

    // R2: address-only native write, NACK
    start_tx(20'h00200, 4'h8, 8'h80);
    chk("R2", lk_len, 5'd0);
    rsp_after(0, 2'd1);
    wait_idle();
    rd(4'd7, v); chk("R6", v, 8'h20);

    // R8: no reply at all
    start_tx(20'h00300, 4'h9, 8'h00);
    wait_idle();
    rd(4'd7, v); chk("R8", v, 8'hE0);

    // R8: reply in the expiry cycle wins; one cycle later it is ignored
    start_tx(20'h00300, 4'h9, 8'h00);
    rsp_after(7, 2'd0);
    wait_idle();
    rd(4'd7, v); chk("R8", v, 8'h60);
    start_tx(20'h00300, 4'h9, 8'h00);
    rsp_after(8, 2'd0);
    wait_idle();
    rd(4'd7, v); chk("R8", v, 8'hE0);

    // R5: busy readback and a second start while busy
    start_tx(20'h00400, 4'h8, 8'h80);
    rd(4'd6, v); chk("R5", v, 8'h01);
    wr(4'd6, 8'h01);
    chk("R5", lk_req, 1'b0);
    rsp_after(0, 2'd2);
    wait_idle();
    rd(4'd7, v); chk("R6", v, 8'h40);

    // R6: I2C write NACK after one of two bytes
    wr(4'd4, 8'h77); wr(4'd4, 8'h88);
    start_tx(20'h00050, 4'h0, 8'h01);
    lk_wtake = 1; @(negedge clk); lk_wtake = 0;
    rsp_after(0, 2'd1);
    wait_idle();
    rd(4'd7, v); chk("R6", v, 8'hA1);

    // R11: overflow of the write FIFO (one byte left over)
    for (int i = 0; i < 16; i++) wr(4'd4, 8'(i));
    rd(4'd9, v); chk("R11", v, 8'h01);

    // R10: clear aborts a transaction in flight
    wr(4'd8, 8'hFF);
    rd(4'd9, v); chk("R10", v, 8'h00);
    start_tx(20'h00500, 4'h9, 8'h00);
    wr(4'd8, 8'hFF);
    rd(4'd6, v); chk("R10", v, 8'h00);
    rd(4'd7, v); chk("R10", v, 8'h00);

    repeat (4) @(negedge clk);
    finish_sim();
  end

endmodule